// File: doc/BRIEF.md
# Transmit Dominant Guard

This block sits between a bus controller's transmit line and the output stage of a differential bus driver. It decides, cycle by cycle, whether the driver may force the bus dominant. Transmit data low asks for a dominant bus and high asks for recessive. The block passes that request on only when four conditions all hold: the node is in normal mode, the I/O supply is healthy, no stuck-low timeout is active and no thermal shutdown is active.

A transmit line stuck low would block every other node. To prevent this, a cycle counter starts on each falling edge of the effective transmit data. If the line stays low for the full timeout window, the driver is released and the block reports the timeout. The next high sample clears the timeout.

An overtemperature indication latches a thermal disable. That disable clears only once the temperature flag has dropped and transmit data is high at the same time. While the I/O supply is undervoltage, the block withdraws its bus engagement entirely. A transmit input flagged as disconnected counts as high.

Top module: `can_tx_guard`

## Requirements
- R1: `drive_dom` is 1 in the same cycle exactly when `standby`=0, `io_uv`=0, `timeout_flag`=0, `thermal_flag`=0 and the effective transmit data is 0. Effective transmit data is `txd_in` OR `txd_open`, and 0 means dominant.
- R2: A falling edge of effective transmit data starts the timer. After TIMEOUT_CYC consecutive rising clock edges that sample it low, `timeout_flag` goes to 1 on that edge. The dominant command therefore lasts exactly TIMEOUT_CYC cycles.
- R3: The first rising edge that samples effective transmit data high clears `timeout_flag`. A later falling edge restarts the count from zero, so a low run shorter than TIMEOUT_CYC never sets the flag.
- R4: While `standby`=1, `drive_dom` is 0. The timeout timer and the thermal latch keep working in standby.
- R5: A rising edge that samples `over_temp`=1 sets `thermal_flag` on that edge, and `drive_dom` is 0 while the flag is set.
- R6: `thermal_flag` clears only on an edge that samples `over_temp`=0 together with effective transmit data high. It stays set while transmit data remains low, even after the temperature has fallen.
- R7: `txd_open`=1 makes the transmit input act as high, whatever `txd_in` is. This releases the bus and clears the timeout.
- R8: While `io_uv`=1, `bus_engage` and `drive_dom` are both 0. `bus_engage` returns to 1 in the same cycle that `io_uv` falls.
- R9: After reset, `timeout_flag` and `thermal_flag` are 0 and `bus_engage` equals NOT `io_uv`.
- R10: The timeout and thermal disables are reported independently and can both be 1 at once. Each clears only under its own release condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txd_in | input | 1 | Transmit data from the controller, 0 = dominant |
| txd_open | input | 1 | 1 when the transmit input is detected as disconnected |
| standby | input | 1 | 1 = standby mode, 0 = normal mode |
| over_temp | input | 1 | Overtemperature indication |
| io_uv | input | 1 | I/O supply undervoltage indication |
| drive_dom | output | 1 | Command to the driver to force the bus dominant |
| bus_engage | output | 1 | Driver may connect to and load the bus |
| timeout_flag | output | 1 | Stuck-low timeout disable active |
| thermal_flag | output | 1 | Thermal shutdown disable active |

## Verification
The bench builds the block with TIMEOUT_CYC set to 20 instead of the default of several hundred thousand cycles. With that value, low runs of 19, 20 and 25 cycles fit easily in a short run. The exact edge where the timeout sets, and the edge where it clears, can then be observed directly. The short window also allows several timeouts to be combined with thermal events, standby and supply loss within one run.

// File: rtl/can_tx_guard.sv
module can_tx_guard #(
  parameter int TIMEOUT_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic txd_open,
  input  logic standby,
  input  logic over_temp,
  input  logic io_uv,
  output logic drive_dom,
  output logic bus_engage,
  output logic timeout_flag,
  output logic thermal_flag
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic          txd_eff;
  logic          txd_q;
  logic          fall;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  assign txd_eff = txd_in | txd_open;
  assign fall    = txd_q & ~txd_eff;
  assign cnt_nx  = fall ? CW'(1) : cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q        <= 1'b1;
      cnt          <= '0;
      timeout_flag <= 1'b0;
      thermal_flag <= 1'b0;
    end else begin
      txd_q        <= txd_eff;
      thermal_flag <= over_temp | (thermal_flag & ~txd_eff);
      if (txd_eff) begin
        cnt          <= '0;
        timeout_flag <= 1'b0;
      end else if (!timeout_flag) begin
        cnt          <= cnt_nx;
        timeout_flag <= (cnt_nx == CW'(TIMEOUT_CYC));
      end
    end
  end

  assign bus_engage = ~io_uv;
  assign drive_dom  = ~standby & ~io_uv & ~timeout_flag & ~thermal_flag & ~txd_eff;
endmodule

// File: rtl/can_tx_guard_chk.sv
module can_tx_guard_chk #(
  parameter int TIMEOUT_CYC = 250000
) (
  input logic clk,
  input logic rst_n,
  input logic txd_in,
  input logic txd_open,
  input logic standby,
  input logic over_temp,
  input logic io_uv,
  input logic drive_dom,
  input logic bus_engage,
  input logic timeout_flag,
  input logic thermal_flag
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (txd_in | txd_open) low_run <= 0;
    else if (low_run < TIMEOUT_CYC + 2) low_run <= low_run + 1;
  end

  a_r1_dom_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    drive_dom |-> (!txd_in && !txd_open && !standby && !io_uv));
  a_r2_timeout_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> (low_run == TIMEOUT_CYC));
  a_r3_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_in || txd_open) |=> !timeout_flag);
  a_r3_timeout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> !drive_dom);
  a_r4_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !drive_dom);
  a_r5_hot_sets: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> (thermal_flag && !drive_dom));
  a_r6_release_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(thermal_flag) |-> $past(!over_temp && (txd_in || txd_open)));
  a_r8_uv_detach: assert property (@(posedge clk) disable iff (!rst_n)
    io_uv |-> (!bus_engage && !drive_dom));
endmodule

bind can_tx_guard can_tx_guard_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .txd_open(txd_open),
  .standby(standby), .over_temp(over_temp), .io_uv(io_uv),
  .drive_dom(drive_dom), .bus_engage(bus_engage),
  .timeout_flag(timeout_flag), .thermal_flag(thermal_flag)
);

// File: tb/can_tx_guard_bench.sv
module can_tx_guard_bench;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_in = 1'b1, txd_open = 1'b0, standby = 1'b0, over_temp = 1'b0, io_uv = 1'b0;
  logic drive_dom, bus_engage, timeout_flag, thermal_flag;

  int total = 0, bad = 0;
  bit done = 0;

  int low_m;
  bit to_m, th_m;

  always #4 clk = ~clk;

  can_tx_guard #(.TIMEOUT_CYC(TO)) u_can_tx_guard (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .txd_open(txd_open),
    .standby(standby), .over_temp(over_temp), .io_uv(io_uv),
    .drive_dom(drive_dom), .bus_engage(bus_engage),
    .timeout_flag(timeout_flag), .thermal_flag(thermal_flag)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_m = 0; to_m = 0; th_m = 0;
    end else begin
      if (txd_in || txd_open) begin
        low_m = 0; to_m = 0;
      end else begin
        low_m++;
        if (low_m >= TO) to_m = 1;
      end
      th_m = over_temp || (th_m && !(txd_in || txd_open));
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit eff;
      eff = txd_in || txd_open;
      chk("R1 drive_dom", drive_dom, !standby && !io_uv && !to_m && !th_m && !eff);
      chk("R3 timeout_flag", timeout_flag, to_m);
      chk("R6 thermal_flag", thermal_flag, th_m);
      chk("R8 bus_engage", bus_engage, !io_uv);
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    hold(3);
    chk("R9 reset timeout", timeout_flag, 1'b0);
    chk("R9 reset thermal", thermal_flag, 1'b0);
    rst_n = 1'b1;
    hold(2);
    chk("R9 idle recessive", drive_dom, 1'b0);

    for (int k = 1; k < 8; k++) begin
      txd_in = 1'b0; hold(k + 2);
      txd_in = 1'b1; hold(k);
    end

    txd_in = 1'b0; hold(TO - 1);
    chk("R2 still dominant", drive_dom, 1'b1);
    hold(1);
    chk("R2 timeout set", timeout_flag, 1'b1);
    chk("R2 bus released", drive_dom, 1'b0);
    hold(5);
    txd_in = 1'b1; hold(1);
    chk("R3 cleared by high", timeout_flag, 1'b0);
    txd_in = 1'b0; hold(TO - 1);
    chk("R3 restarted count", timeout_flag, 1'b0);
    txd_in = 1'b1; hold(2);

    txd_in = 1'b0; hold(3);
    over_temp = 1'b1; hold(1);
    chk("R5 thermal set", thermal_flag, 1'b1);
    chk("R5 driver off", drive_dom, 1'b0);
    over_temp = 1'b0; hold(4);
    chk("R6 held while low", thermal_flag, 1'b1);
    txd_in = 1'b1; over_temp = 1'b1; hold(2);
    chk("R6 held while hot", thermal_flag, 1'b1);
    over_temp = 1'b0; hold(1);
    chk("R6 released", thermal_flag, 1'b0);

    standby = 1'b1; txd_in = 1'b0; hold(4);
    chk("R4 standby quiet", drive_dom, 1'b0);
    hold(TO);
    chk("R4 timer runs in standby", timeout_flag, 1'b1);
    txd_in = 1'b1; standby = 1'b0; hold(2);

    txd_in = 1'b0; hold(2);
    txd_open = 1'b1; #1;
    chk("R7 open is recessive", drive_dom, 1'b0);
    hold(TO + 3);
    chk("R7 no timeout when open", timeout_flag, 1'b0);
    txd_open = 1'b0; txd_in = 1'b1; hold(2);

    txd_in = 1'b0; hold(2);
    io_uv = 1'b1; #1;
    chk("R8 detach", bus_engage, 1'b0);
    chk("R8 no drive", drive_dom, 1'b0);
    hold(3);
    io_uv = 1'b0; #1;
    chk("R8 reattach", bus_engage, 1'b1);
    chk("R8 drive resumes", drive_dom, 1'b1);
    txd_in = 1'b1; hold(2);

    txd_in = 1'b0; hold(TO);
    over_temp = 1'b1; hold(2);
    chk("R10 both timeout", timeout_flag, 1'b1);
    chk("R10 both thermal", thermal_flag, 1'b1);
    over_temp = 1'b0; hold(1);
    txd_in = 1'b1; hold(1);
    chk("R10 timeout cleared", timeout_flag, 1'b0);
    chk("R10 thermal cleared", thermal_flag, 1'b0);
    hold(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule